// File: doc/BRIEF.md
# Endpoint Buffer Memory Allocator

This block divides one shared buffer RAM among up to eight USB pipes or endpoints. Firmware writes a per-endpoint control word through a single write port. The word holds an allocate flag, an enable flag, a 3-bit packet-size code and a double-bank flag. The block keeps a start address for each endpoint. It flags each endpoint whose region collides with the next reserved region or runs past the end of the RAM. It also maps an endpoint number plus a byte offset onto a physical RAM address.

Regions are expected to be reserved in rising endpoint order, starting at endpoint 0. Reserving or releasing endpoint k moves two bases at most: the base of k itself and the base of k+1. Bases of higher endpoints do not move. After an out-of-order reservation, or a re-reservation with a larger size, regions can overlap or leave unused gaps. The block does not repair these cases; it reports them through the per-endpoint collision flags.

Top module: `ep_buf_alloc`

## Requirements
- R1: After reset, all control fields, all bases, the busy output, all collision flags and the translator valid output are zero.
- R2: When the allocate flag of endpoint k goes from 0 to 1, the base of k becomes the end of endpoint k-1. That end is the base of k-1 plus its region size if k-1 is allocated, otherwise the base of k-1 alone. Endpoint 0 always starts at 0. The region size is 8 << code bytes for codes 0 to 6, and 512 bytes for code 7, doubled when the double-bank flag is 1.
- R3: In the same update as R2, the base of endpoint k+1 becomes the new end of endpoint k.
- R4: When the allocate flag of endpoint k goes from 1 to 0, the base of k keeps its value and the base of k+1 becomes the end of endpoint k-1.
- R5: An allocate or free on endpoint k leaves the bases of endpoints k+2 and above unchanged. At most two bases change per update.
- R6: A write that does not change the allocate flag moves no base and raises no busy. This includes a write that only clears the enable flag. Such a write stores the new enable, size and bank fields, and the endpoint stays allocated.
- R7: A base change caused by a write appears after the second rising edge that follows the write cycle. busy_o is high exactly in the cycle between those two edges.
- R8: For an allocated endpoint i, conflict_o[i] is 1 when base + region size is greater than the base of the next higher allocated endpoint, or greater than 2048. It is 0 otherwise and for unallocated endpoints. The flag is combinational on the current state.
- R9: xl_addr_o is the low 11 bits of base(xl_ep_i) + xl_off_i. xl_valid_o is 1 only when that endpoint is allocated and xl_off_i is smaller than its region size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control-word write strobe |
| wr_ep_i | input | 3 | Endpoint written |
| wr_alloc_i | input | 1 | Allocate flag |
| wr_enable_i | input | 1 | Enable flag |
| wr_size_i | input | 3 | Packet-size code |
| wr_dbl_i | input | 1 | Double-bank flag |
| busy_o | output | 1 | Base update in progress |
| alloc_o | output | 8 | Allocate flag per endpoint |
| enable_o | output | 8 | Enable flag per endpoint |
| conflict_o | output | 8 | Collision flag per endpoint |
| base_o | output | 112 | Base per endpoint, 14 bits each, endpoint i at bits [14i+13:14i] |
| xl_ep_i | input | 3 | Translator endpoint |
| xl_off_i | input | 11 | Translator byte offset |
| xl_addr_o | output | 11 | Physical RAM address |
| xl_valid_o | output | 1 | Translation within an allocated region |

## Verification
The first input pattern is an in-order reservation of endpoints 0 to 5 with mixed sizes and bank counts. It checks that each base equals the sum of the regions below it. The second pattern frees and then re-reserves a middle endpoint with a larger size. This separates k+1 sliding from k+2 staying in place, and it produces a neighbour overlap. Writes that only toggle the enable flag show that fields are retained without any base motion. Reserving the top two endpoints at maximum size triggers the RAM-limit flag. Translator probes at offset 0, at the last byte, one byte past the end, on an unallocated endpoint and on a region that wraps the address range check the validity bound and the address truncation.

// File: rtl/ep_alloc_pkg.sv
package ep_alloc_pkg;
  typedef struct packed {
    logic       alloc;
    logic       enable;
    logic [2:0] size;
    logic       dbl;
  } ep_cfg_t;

  typedef enum logic [1:0] {OP_NONE, OP_ALLOC, OP_FREE} op_e;

  localparam int unsigned REG_W = 11;

  function automatic logic [REG_W-1:0] region_bytes(input ep_cfg_t c);
    logic [REG_W-1:0] pkt;
    pkt = (c.size == 3'd7) ? REG_W'(512) : (REG_W'(8) << c.size);
    return c.dbl ? (pkt << 1) : pkt;
  endfunction
endpackage

// File: rtl/ep_cfg_regs.sv
module ep_cfg_regs
  import ep_alloc_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  localparam int unsigned EP_W = $clog2(NUM_EP)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [EP_W-1:0] wr_ep_i,
  input  ep_cfg_t         wr_cfg_i,
  output ep_cfg_t         cfg_o [NUM_EP],
  output op_e             op_o,
  output logic [EP_W-1:0] op_ep_o
);
  ep_cfg_t cfg_q [NUM_EP];
  ep_cfg_t old_cfg;

  assign old_cfg = cfg_q[wr_ep_i];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cfg_q[i] <= '0;
      else if (wr_en_i && wr_ep_i == EP_W'(i))      cfg_q[i] <= wr_cfg_i;
    end
    assign cfg_o[i] = cfg_q[i];
  end

  // only a change of the allocate flag schedules a base update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o    <= OP_NONE;
      op_ep_o <= '0;
    end else begin
      op_ep_o <= wr_ep_i;
      if (wr_en_i && !old_cfg.alloc && wr_cfg_i.alloc)      op_o <= OP_ALLOC;
      else if (wr_en_i && old_cfg.alloc && !wr_cfg_i.alloc) op_o <= OP_FREE;
      else                                                  op_o <= OP_NONE;
    end
  end
endmodule

// File: rtl/ep_base_ctrl.sv
module ep_base_ctrl
  import ep_alloc_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  parameter int unsigned BASE_W = 14,
  localparam int unsigned EP_W = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ep_cfg_t           cfg_i [NUM_EP],
  input  op_e               op_i,
  input  logic [EP_W-1:0]   op_ep_i,
  output logic [BASE_W-1:0] base_o [NUM_EP]
);
  logic [BASE_W-1:0] base_q [NUM_EP];
  logic [BASE_W-1:0] end_w  [NUM_EP];
  logic [BASE_W-1:0] prev_end, new_end;

  always_comb begin
    for (int i = 0; i < NUM_EP; i++)
      end_w[i] = base_q[i] + (cfg_i[i].alloc ? BASE_W'(region_bytes(cfg_i[i])) : '0);
  end

  always_comb begin
    prev_end = '0;
    for (int i = 1; i < NUM_EP; i++)
      if (op_ep_i == EP_W'(i)) prev_end = end_w[i-1];
  end

  assign new_end = prev_end + BASE_W'(region_bytes(cfg_i[op_ep_i]));

  for (genvar i = 0; i < NUM_EP; i++) begin : g_base
    logic self_hit, next_hit;
    assign self_hit = (op_i == OP_ALLOC) && (op_ep_i == EP_W'(i));
    if (i == 0) begin : g_first
      assign next_hit = 1'b0;
    end else begin : g_rest
      assign next_hit = (op_i != OP_NONE) && (op_ep_i == EP_W'(i-1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       base_q[i] <= '0;
      else if (self_hit) base_q[i] <= prev_end;
      else if (next_hit) base_q[i] <= (op_i == OP_ALLOC) ? new_end : prev_end;
    end
    assign base_o[i] = base_q[i];
  end
endmodule

// File: rtl/ep_conflict_chk.sv
module ep_conflict_chk
  import ep_alloc_pkg::*;
#(
  parameter int unsigned NUM_EP    = 8,
  parameter int unsigned BASE_W    = 14,
  parameter int unsigned RAM_BYTES = 2048
) (
  input  ep_cfg_t           cfg_i  [NUM_EP],
  input  logic [BASE_W-1:0] base_i [NUM_EP],
  output logic [NUM_EP-1:0] conflict_o
);
  localparam logic [BASE_W-1:0] RAM_LIM = BASE_W'(RAM_BYTES);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_cf
    logic              has_nxt;
    logic [BASE_W-1:0] nxt_base, end_i;

    // nearest allocated endpoint above i
    always_comb begin
      has_nxt  = 1'b0;
      nxt_base = '0;
      for (int j = NUM_EP - 1; j > i; j--) begin
        if (cfg_i[j].alloc) begin
          has_nxt  = 1'b1;
          nxt_base = base_i[j];
        end
      end
    end

    assign end_i = base_i[i] + BASE_W'(region_bytes(cfg_i[i]));
    assign conflict_o[i] = cfg_i[i].alloc &&
                           ((has_nxt && end_i > nxt_base) || end_i > RAM_LIM);
  end
endmodule

// File: rtl/ep_addr_xlat.sv
module ep_addr_xlat
  import ep_alloc_pkg::*;
#(
  parameter int unsigned NUM_EP = 8,
  parameter int unsigned BASE_W = 14,
  parameter int unsigned ADDR_W = 11,
  localparam int unsigned EP_W = $clog2(NUM_EP)
) (
  input  ep_cfg_t           cfg_i  [NUM_EP],
  input  logic [BASE_W-1:0] base_i [NUM_EP],
  input  logic [EP_W-1:0]   ep_i,
  input  logic [ADDR_W-1:0] off_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  ep_cfg_t           sel_cfg;
  logic [BASE_W-1:0] sel_base;
  logic [BASE_W-1:0] sum;

  assign sel_cfg  = cfg_i[ep_i];
  assign sel_base = base_i[ep_i];
  assign sum      = sel_base + BASE_W'(off_i);
  assign addr_o   = sum[ADDR_W-1:0];
  assign valid_o  = sel_cfg.alloc &&
                    (BASE_W'(off_i) < BASE_W'(region_bytes(sel_cfg)));
endmodule

// File: rtl/ep_buf_alloc.sv
module ep_buf_alloc
  import ep_alloc_pkg::*;
#(
  parameter int unsigned NUM_EP    = 8,
  parameter int unsigned RAM_BYTES = 2048,
  localparam int unsigned EP_W   = $clog2(NUM_EP),
  localparam int unsigned ADDR_W = $clog2(RAM_BYTES),
  localparam int unsigned BASE_W = ADDR_W + 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [EP_W-1:0]          wr_ep_i,
  input  logic                     wr_alloc_i,
  input  logic                     wr_enable_i,
  input  logic [2:0]               wr_size_i,
  input  logic                     wr_dbl_i,
  output logic                     busy_o,
  output logic [NUM_EP-1:0]        alloc_o,
  output logic [NUM_EP-1:0]        enable_o,
  output logic [NUM_EP-1:0]        conflict_o,
  output logic [NUM_EP*BASE_W-1:0] base_o,
  input  logic [EP_W-1:0]          xl_ep_i,
  input  logic [ADDR_W-1:0]        xl_off_i,
  output logic [ADDR_W-1:0]        xl_addr_o,
  output logic                     xl_valid_o
);
  ep_cfg_t           cfg [NUM_EP];
  ep_cfg_t           wr_cfg;
  op_e               op;
  logic [EP_W-1:0]   op_ep;
  logic [BASE_W-1:0] base [NUM_EP];

  assign wr_cfg = '{alloc: wr_alloc_i, enable: wr_enable_i, size: wr_size_i, dbl: wr_dbl_i};

  ep_cfg_regs #(.NUM_EP(NUM_EP)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_ep_i,
    .wr_cfg_i(wr_cfg), .cfg_o(cfg), .op_o(op), .op_ep_o(op_ep)
  );

  ep_base_ctrl #(.NUM_EP(NUM_EP), .BASE_W(BASE_W)) u_base (
    .clk_i, .rst_ni, .cfg_i(cfg), .op_i(op), .op_ep_i(op_ep), .base_o(base)
  );

  ep_conflict_chk #(.NUM_EP(NUM_EP), .BASE_W(BASE_W), .RAM_BYTES(RAM_BYTES)) u_cf (
    .cfg_i(cfg), .base_i(base), .conflict_o
  );

  ep_addr_xlat #(.NUM_EP(NUM_EP), .BASE_W(BASE_W), .ADDR_W(ADDR_W)) u_xl (
    .cfg_i(cfg), .base_i(base), .ep_i(xl_ep_i), .off_i(xl_off_i),
    .addr_o(xl_addr_o), .valid_o(xl_valid_o)
  );

  assign busy_o = (op != OP_NONE);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_out
    assign alloc_o[i]                  = cfg[i].alloc;
    assign enable_o[i]                 = cfg[i].enable;
    assign base_o[i*BASE_W +: BASE_W]  = base[i];
  end
endmodule

// File: rtl/ep_alloc_chk.sv
module ep_alloc_chk #(
  parameter int unsigned NUM_EP = 8,
  parameter int unsigned BASE_W = 14,
  parameter int unsigned EP_W   = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic                     busy_o,
  input logic [NUM_EP-1:0]        alloc_o,
  input logic [NUM_EP-1:0]        conflict_o,
  input logic [NUM_EP*BASE_W-1:0] base_o,
  input logic [EP_W-1:0]          xl_ep_i,
  input logic                     xl_valid_o
);
  logic [NUM_EP*BASE_W-1:0] prev_q;
  logic [NUM_EP-1:0]        chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= base_o;
  end

  for (genvar i = 0; i < NUM_EP; i++) begin : g_chg
    assign chg[i] = base_o[i*BASE_W +: BASE_W] != prev_q[i*BASE_W +: BASE_W];
  end

  a_r7_busy_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $past(wr_en_i));

  a_r7_move_only_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(base_o) |-> $past(busy_o));

  a_r5_two_moves_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chg) <= 2);

  a_r9_valid_needs_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_valid_o |-> alloc_o[xl_ep_i]);

  a_r8_flag_needs_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conflict_o & ~alloc_o) == '0);
endmodule

bind ep_buf_alloc ep_alloc_chk #(.NUM_EP(NUM_EP), .BASE_W(BASE_W), .EP_W(EP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .busy_o(busy_o),
  .alloc_o(alloc_o), .conflict_o(conflict_o), .base_o(base_o),
  .xl_ep_i(xl_ep_i), .xl_valid_o(xl_valid_o)
);

// File: tb/sim_ep_buf_alloc.sv
module sim_ep_buf_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 14;
  localparam int NV = 9;

  typedef struct packed {
    logic [2:0]  ep;
    logic        al;
    logic        en;
    logic [2:0]  sz;
    logic        dbl;
    logic        busy;
    logic [13:0] bk, bk1, bk2;
    logic [7:0]  cf;
  } vec_t;

  // bases of k, k+1, k+2 after each write; sizes 8<<code, doubled if dbl
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b1, 1'b0, 3'd3, 1'b0, 1'b1, 14'd0,   14'd64,  14'd0,   8'h00},
    '{3'd1, 1'b1, 1'b0, 3'd4, 1'b1, 1'b1, 14'd64,  14'd320, 14'd0,   8'h00},
    '{3'd2, 1'b1, 1'b0, 3'd5, 1'b0, 1'b1, 14'd320, 14'd576, 14'd0,   8'h00},
    '{3'd3, 1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 14'd576, 14'd640, 14'd0,   8'h00},
    '{3'd4, 1'b1, 1'b0, 3'd3, 1'b0, 1'b1, 14'd640, 14'd704, 14'd0,   8'h00},
    '{3'd5, 1'b1, 1'b0, 3'd3, 1'b0, 1'b1, 14'd704, 14'd768, 14'd0,   8'h00},
    '{3'd3, 1'b1, 1'b1, 3'd2, 1'b1, 1'b0, 14'd576, 14'd640, 14'd704, 8'h00},
    '{3'd3, 1'b0, 1'b0, 3'd2, 1'b1, 1'b1, 14'd576, 14'd576, 14'd704, 8'h00},
    '{3'd3, 1'b1, 1'b0, 3'd4, 1'b0, 1'b1, 14'd576, 14'd704, 14'd704, 8'h10}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_ep_i = '0;
  logic        wr_alloc_i = 1'b0, wr_enable_i = 1'b0, wr_dbl_i = 1'b0;
  logic [2:0]  wr_size_i = '0;
  logic        busy_o, xl_valid_o;
  logic [7:0]  alloc_o, enable_o, conflict_o;
  logic [8*BW-1:0] base_o;
  logic [2:0]  xl_ep_i = '0;
  logic [10:0] xl_off_i = '0, xl_addr_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ep_buf_alloc u0 (.*);

  function automatic int base_of(int i);
    return int'(base_o[i*BW +: BW]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ep, input bit al, input bit en, input int sz, input bit d,
                    output bit busy_seen);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_ep_i = 3'(ep); wr_alloc_i = al; wr_enable_i = en;
    wr_size_i = 3'(sz); wr_dbl_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    busy_seen = busy_o;
    @(negedge clk_i);
  endtask

  task automatic xl(input int ep, input int off, input int exp_addr, input bit exp_v,
                    input string req);
    xl_ep_i = 3'(ep); xl_off_i = 11'(off);
    #1;
    check(xl_valid_o == exp_v, req, xl_valid_o, exp_v);
    if (exp_v) check(int'(xl_addr_o) == exp_addr, req, xl_addr_o, exp_addr);
  endtask

  initial begin
    bit b;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(busy_o == 1'b0, "R1 busy", busy_o, 0);
    check(alloc_o == '0 && enable_o == '0, "R1 fields", alloc_o, 0);
    check(base_o == '0, "R1 bases", base_o != '0, 0);
    check(conflict_o == '0, "R1 conflict", conflict_o, 0);
    xl(0, 0, 0, 1'b0, "R1 xl_valid");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(busy_o == 1'b0 && base_o == '0, "R1 after release", busy_o, 0);

    // table: R2/R3 allocation, R4 free, R5 k+2 stays, R6 enable-only, R7 busy, R8 overlap
    for (int v = 0; v < NV; v++) begin
      wr(VEC[v].ep, VEC[v].al, VEC[v].en, VEC[v].sz, VEC[v].dbl, b);
      check(b == VEC[v].busy, "R7 busy window", b, VEC[v].busy);
      check(busy_o == 1'b0, "R7 busy drops", busy_o, 0);
      check(base_of(VEC[v].ep) == VEC[v].bk, "R2/R4 base k", base_of(VEC[v].ep), VEC[v].bk);
      check(base_of(VEC[v].ep + 1) == VEC[v].bk1, "R3/R4 base k+1",
            base_of(VEC[v].ep + 1), VEC[v].bk1);
      check(base_of(VEC[v].ep + 2) == VEC[v].bk2, "R5 base k+2",
            base_of(VEC[v].ep + 2), VEC[v].bk2);
      check(conflict_o == VEC[v].cf, "R8 conflict", conflict_o, VEC[v].cf);
      check(enable_o[VEC[v].ep] == VEC[v].en, "R6 enable field", enable_o[VEC[v].ep], VEC[v].en);
    end

    // R9 translator bounds on ep2 (base 320, 256 bytes)
    xl(2, 0, 320, 1'b1, "R9 first byte");
    xl(2, 255, 575, 1'b1, "R9 last byte");
    xl(2, 256, 0, 1'b0, "R9 past end");
    xl(6, 0, 0, 1'b0, "R9 unallocated");

    // R2 with code 7 double bank = 1024 bytes
    wr(6, 1'b1, 1'b0, 7, 1'b1, b);
    check(base_of(6) == 768, "R2 ep6 base", base_of(6), 768);
    check(base_of(7) == 1792, "R3 ep7 base", base_of(7), 1792);
    check(conflict_o == 8'h10, "R8 no ram overflow", conflict_o, 8'h10);
    // R8 ram limit: ep7 ends at 2816
    wr(7, 1'b1, 1'b0, 7, 1'b1, b);
    check(base_of(7) == 1792, "R2 ep7 base", base_of(7), 1792);
    check(conflict_o == 8'h90, "R8 ram limit", conflict_o, 8'h90);
    xl(7, 300, 44, 1'b1, "R9 address wrap");

    // R6 enable on then off on ep2: no move, still allocated, size kept
    wr(2, 1'b1, 1'b1, 5, 1'b0, b);
    check(b == 1'b0, "R6 no busy", b, 0);
    check(enable_o[2] == 1'b1, "R6 enable set", enable_o[2], 1);
    wr(2, 1'b1, 1'b0, 5, 1'b0, b);
    check(b == 1'b0, "R6 no busy", b, 0);
    check(enable_o[2] == 1'b0 && alloc_o[2] == 1'b1, "R6 alloc kept", alloc_o[2], 1);
    check(base_of(2) == 320 && base_of(3) == 576, "R6 bases kept", base_of(3), 576);
    xl(2, 255, 575, 1'b1, "R6 size kept");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule